// File: doc/BRIEF.md
# Signed Fractional Multiplier with Rounding and Saturation

This block is one lane of a fixed-point vector datapath. It treats two SEW-bit signed operands as fractions in the range [-1, 1). It forms their exact double-width product and scales the result back to SEW bits by an arithmetic right shift of SEW-1 places. The bits that the shift discards are rounded under one of four selectable modes. The rounded value is then clamped into the signed SEW-bit range, and a flag reports whenever the clamp changed the value.

The second operand comes from one of two inputs. One carries a per-element value and the other a broadcast scalar, and a select pin chooses between them on each transfer.

Data enters and leaves through valid/ready streams. A transfer happens on a rising clock edge when both valid and ready are high. The pipeline has two register stages and advances as a whole. Whenever the output register is empty or is being drained, the pipeline accepts one operation per cycle. While the output holds a result that the sink has not taken, `in_ready` is low and the output stays frozen. `in_ready` depends combinationally on `out_ready`. With `out_ready` held high, a result appears two cycles after its operands were accepted.

Top module: `fxmul_lane`

## Requirements
- R1: `out_data` equals the full-precision signed product `a*b`, shifted right arithmetically by SEW-1 bits, rounded by the selected mode, and clamped to the signed SEW-bit range.
- R2: With `in_mode` = 2'b00 (nearest, ties up), 1 is added to the shifted value when the most significant discarded bit is 1.
- R3: With `in_mode` = 2'b01 (nearest, ties to even), 1 is added when the discarded part is more than half an output LSB, or when it is exactly half and the shifted value is odd.
- R4: With `in_mode` = 2'b10 (truncate), the shifted value is used unchanged, which gives the floor of the scaled product.
- R5: With `in_mode` = 2'b11 (jam to odd), the LSB of the shifted value is forced to 1 whenever any discarded bit is nonzero.
- R6: The most negative operand times the most negative operand gives the largest positive SEW-bit value, with `out_sat` = 1, in every rounding mode.
- R7: `out_sat` is 1 only when the clamp changed the value. For every other operand pair it is 0.
- R8: With `out_ready` held high, each accepted operation appears at the output exactly two cycles later, and `in_ready` stays high so that one operation is accepted every cycle.
- R9: While `out_valid` is 1 and `out_ready` is 0, `out_valid`, `out_data` and `out_sat` hold their values on the next cycle.
- R10: `in_ready` is 0 whenever `out_valid` is 1 and `out_ready` is 0.
- R11: While `rst_n` is low and on release, `out_valid` is 0 and `in_ready` is 1.
- R12: With `in_use_scalar` = 1 the second operand is `in_b_scalar`, and with 0 it is `in_b_vec`. The unselected input has no effect on the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operands and mode are valid |
| in_ready | output | 1 | Lane can accept an operation this cycle |
| in_a | input | SEW | First signed operand |
| in_b_vec | input | SEW | Second signed operand, per element |
| in_b_scalar | input | SEW | Second signed operand, broadcast scalar |
| in_use_scalar | input | 1 | 1 selects `in_b_scalar`, 0 selects `in_b_vec` |
| in_mode | input | 2 | Rounding mode: 00 nearest-up, 01 nearest-even, 10 truncate, 11 jam-to-odd |
| out_valid | output | 1 | Result is valid |
| out_ready | input | 1 | Sink takes the result this cycle |
| out_data | output | SEW | Rounded and clamped signed result |
| out_sat | output | 1 | Result was clamped |

## Verification
The assertions check the stream rules on every cycle. They cover the output holding under back-pressure, `in_ready` dropping while the output is stalled, and each stage filling on the cycle after a transfer. They also check that a raised saturation flag always comes with the largest positive value, and that it comes only from the min-by-min product held in the first stage.

The arithmetic itself can only be shown by the bench scenarios. These compare results against a remainder-based model: the ties and residues of each rounding mode, the min-by-min corner in all modes, and the choice of scalar over vector operand. The exact two-cycle latency and the full throughput are measured in a phase where the sink is always ready.

// File: rtl/fxmul_pkg.sv
package fxmul_pkg;

  // Rounding applied to the bits discarded by the fractional rescale.
  typedef enum logic [1:0] {
    RND_NEAR_UP   = 2'b00,
    RND_NEAR_EVEN = 2'b01,
    RND_TRUNC     = 2'b10,
    RND_JAM_ODD   = 2'b11
  } rnd_mode_e;

endpackage

// File: rtl/fxmul_product.sv
// Operand select and exact double-width signed product.
module fxmul_product #(
  parameter int SEW = 16
) (
  input  logic [SEW-1:0]          a,
  input  logic [SEW-1:0]          b_vec,
  input  logic [SEW-1:0]          b_scalar,
  input  logic                    use_scalar,
  output logic signed [2*SEW-1:0] prod
);
  localparam int PW = 2 * SEW;

  logic [SEW-1:0] b_sel;
  logic [PW-1:0]  a_ext;
  logic [PW-1:0]  b_ext;

  assign b_sel = use_scalar ? b_scalar : b_vec;

  // Sign-extend both to full width so the low PW bits of the product are exact.
  assign a_ext = {{SEW{a[SEW-1]}}, a};
  assign b_ext = {{SEW{b_sel[SEW-1]}}, b_sel};
  assign prod  = $signed(a_ext) * $signed(b_ext);

endmodule

// File: rtl/fxmul_round.sv
// Rescale by SEW-1 and apply the selected rounding increment.
module fxmul_round
  import fxmul_pkg::*;
#(
  parameter int SEW = 16
) (
  input  logic signed [2*SEW-1:0] prod,
  input  rnd_mode_e               mode,
  output logic signed [SEW+1:0]   rounded
);
  localparam int PW = 2 * SEW;
  localparam int SH = SEW - 1;
  localparam int QW = PW - SH;

  logic [QW-1:0] q;
  logic          lsb;
  logic          guard;
  logic          sticky;
  logic          inc;

  assign q      = prod[PW-1:SH];
  assign lsb    = prod[SH];
  assign guard  = prod[SH-1];
  assign sticky = |prod[SH-2:0];

  always_comb begin
    unique case (mode)
      RND_NEAR_UP:   inc = guard;
      RND_NEAR_EVEN: inc = guard & (sticky | lsb);
      RND_TRUNC:     inc = 1'b0;
      RND_JAM_ODD:   inc = ~lsb & (guard | sticky);
      default:       inc = 1'b0;
    endcase
  end

  // One spare bit above the sign keeps the increment from wrapping.
  assign rounded = $signed({q[QW-1], q}) + $signed({{(SEW+1){1'b0}}, inc});

endmodule

// File: rtl/fxmul_clamp.sv
// Clip a widened signed value into the SEW-bit signed range.
module fxmul_clamp #(
  parameter int SEW = 16
) (
  input  logic signed [SEW+1:0] v,
  output logic [SEW-1:0]        res,
  output logic                  sat
);
  localparam logic signed [SEW+1:0] HI = {3'b000, {(SEW-1){1'b1}}};
  localparam logic signed [SEW+1:0] LO = {3'b111, {(SEW-1){1'b0}}};
  localparam logic [SEW-1:0] MAX_POS = {1'b0, {(SEW-1){1'b1}}};
  localparam logic [SEW-1:0] MIN_NEG = {1'b1, {(SEW-1){1'b0}}};

  always_comb begin
    if (v > HI) begin
      res = MAX_POS;
      sat = 1'b1;
    end else if (v < LO) begin
      res = MIN_NEG;
      sat = 1'b1;
    end else begin
      res = v[SEW-1:0];
      sat = 1'b0;
    end
  end

endmodule

// File: rtl/fxmul_lane.sv
// Two-stage valid/ready fractional multiply lane.
module fxmul_lane
  import fxmul_pkg::*;
#(
  parameter int SEW = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           in_valid,
  output logic           in_ready,
  input  logic [SEW-1:0] in_a,
  input  logic [SEW-1:0] in_b_vec,
  input  logic [SEW-1:0] in_b_scalar,
  input  logic           in_use_scalar,
  input  logic [1:0]     in_mode,
  output logic           out_valid,
  input  logic           out_ready,
  output logic [SEW-1:0] out_data,
  output logic           out_sat
);
  localparam int PW = 2 * SEW;
  localparam logic signed [PW-1:0] MINMIN = {2'b01, {(PW-2){1'b0}}};
  localparam logic [SEW-1:0] MAX_POS = {1'b0, {(SEW-1){1'b1}}};

  // Global advance: the pipeline moves when the output slot is free or drains.
  logic adv;
  assign adv      = !out_valid || out_ready;
  assign in_ready = adv;

  // Stage 1: product
  logic signed [PW-1:0] prod_in;
  logic                 s1_valid;
  logic signed [PW-1:0] s1_prod;
  rnd_mode_e            s1_mode;

  fxmul_product #(.SEW(SEW)) u_product (
    .a          (in_a),
    .b_vec      (in_b_vec),
    .b_scalar   (in_b_scalar),
    .use_scalar (in_use_scalar),
    .prod       (prod_in)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_valid <= 1'b0;
      s1_prod  <= '0;
      s1_mode  <= RND_NEAR_UP;
    end else if (adv) begin
      s1_valid <= in_valid;
      if (in_valid) begin
        s1_prod <= prod_in;
        s1_mode <= rnd_mode_e'(in_mode);
      end
    end
  end

  // Stage 2: round, clamp, register
  logic signed [SEW+1:0] rounded;
  logic [SEW-1:0]        clamped;
  logic                  clamp_sat;

  fxmul_round #(.SEW(SEW)) u_round (
    .prod    (s1_prod),
    .mode    (s1_mode),
    .rounded (rounded)
  );

  fxmul_clamp #(.SEW(SEW)) u_clamp (
    .v   (rounded),
    .res (clamped),
    .sat (clamp_sat)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      out_sat   <= 1'b0;
    end else if (adv) begin
      out_valid <= s1_valid;
      if (s1_valid) begin
        out_data <= clamped;
        out_sat  <= clamp_sat;
      end
    end
  end

  // Assertions
  a_r6_sat_is_max: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_sat) |-> (out_data == MAX_POS));

  a_r7_sat_only_minmin: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_valid && adv) |=> (out_sat == ($past(s1_prod) == MINMIN)));

  a_r8_stage1_fill: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> s1_valid);

  a_r8_stage2_fill: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_valid && adv) |=> out_valid);

  a_r9_hold_output: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_sat)));

  a_r10_no_accept_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

endmodule

// File: tb/test_fxmul_lane.sv
module test_fxmul_lane;
  localparam int SEW = 16;

  logic            clk = 1'b0;
  logic            rst_n;
  logic            in_valid;
  logic            in_ready;
  logic [SEW-1:0]  in_a;
  logic [SEW-1:0]  in_b_vec;
  logic [SEW-1:0]  in_b_scalar;
  logic            in_use_scalar;
  logic [1:0]      in_mode;
  logic            out_valid;
  logic            out_ready;
  logic [SEW-1:0]  out_data;
  logic            out_sat;

  always #2 clk = ~clk;

  fxmul_lane #(.SEW(SEW)) i_fxmul_lane (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_a(in_a), .in_b_vec(in_b_vec), .in_b_scalar(in_b_scalar),
    .in_use_scalar(in_use_scalar), .in_mode(in_mode),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .out_sat(out_sat)
  );

  int    n_tests = 0;
  int    n_fail  = 0;
  longint cyc    = 0;
  bit    done    = 0;
  bit    lat_mode = 0;

  always @(posedge clk) cyc <= cyc + 1;

  typedef struct {
    logic [15:0] d;
    logic        s;
    logic [1:0]  m;
    bit          mm;
    bit          sc;
    bit          lat;
    longint      t;
  } exp_t;
  exp_t q[$];

  bit          prev_stall = 0;
  logic [15:0] prev_d;
  logic        prev_s;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Model: floor quotient plus remainder, compared against half an output LSB.
  function automatic void model(input logic signed [15:0] a, input logic signed [15:0] b,
                                input logic [1:0] m, output logic [15:0] d, output logic s);
    longint p, t, rem, r;
    p   = longint'(a) * longint'(b);
    t   = p >>> 15;
    rem = p - t * 32768;
    r   = t;
    case (m)
      2'b00: if (rem >= 16384) r = t + 1;
      2'b01: if (rem > 16384 || (rem == 16384 && t[0])) r = t + 1;
      2'b10: r = t;
      default: if (rem != 0) r = t | 1;
    endcase
    s = 1'b0;
    if (r > 32767) begin r = 32767; s = 1'b1; end
    else if (r < -32768) begin r = -32768; s = 1'b1; end
    d = r[15:0];
  endfunction

  function automatic string mode_tag(input logic [1:0] m);
    case (m)
      2'b00:   return "R2";
      2'b01:   return "R3";
      2'b10:   return "R4";
      default: return "R5";
    endcase
  endfunction

  // Drive one cycle at the falling edge, then observe the handshakes.
  task automatic step(input bit iv, input logic [15:0] a, input logic [15:0] bv,
                      input logic [15:0] bs, input bit us, input logic [1:0] m,
                      input bit ordy);
    exp_t e;
    logic [15:0] bsel;
    @(negedge clk);
    in_valid = iv; in_a = a; in_b_vec = bv; in_b_scalar = bs;
    in_use_scalar = us; in_mode = m; out_ready = ordy;
    #1;
    if (prev_stall) begin
      check(out_valid === 1'b1, "R9", "valid held under stall", out_valid, 1);
      check(out_data === prev_d, "R9", "data held under stall", out_data, prev_d);
      check(out_sat === prev_s, "R9", "sat held under stall", out_sat, prev_s);
    end
    if (out_valid && !out_ready)
      check(in_ready === 1'b0, "R10", "in_ready while stalled", in_ready, 0);
    if (lat_mode)
      check(in_ready === 1'b1, "R8", "in_ready at full rate", in_ready, 1);
    if (out_valid && out_ready) begin
      if (q.size() == 0) begin
        check(1'b0, "R8", "unexpected output", out_data, -1);
      end else begin
        e = q.pop_front();
        check(out_data === e.d,
              e.mm ? "R6" : (e.sc ? "R12" : mode_tag(e.m)),
              "R1 data", out_data, e.d);
        check(out_sat === e.s, e.mm ? "R6" : "R7", "sat flag", out_sat, e.s);
        if (e.lat) check(cyc - e.t == 2, "R8", "latency", cyc - e.t, 2);
      end
    end
    if (in_valid && in_ready) begin
      bsel = us ? bs : bv;
      model(a, bsel, m, e.d, e.s);
      e.m   = m;
      e.mm  = (a == 16'h8000) && (bsel == 16'h8000);
      e.sc  = us;
      e.lat = lat_mode;
      e.t   = cyc;
      q.push_back(e);
    end
    prev_stall = out_valid && !out_ready;
    prev_d = out_data;
    prev_s = out_sat;
  endtask

  function automatic logic [15:0] pick();
    case ($urandom % 10)
      0: return 16'h8000;
      1: return 16'h7FFF;
      2: return 16'h4000;
      3: return 16'hC000;
      4: return 16'h0001;
      5: return 16'hFFFF;
      default: return 16'($urandom);
    endcase
  endfunction

  task automatic drain();
    for (int i = 0; i < 6; i++) step(0, 0, 0, 0, 0, 0, 1);
  endtask

  initial begin
    void'($urandom(32'h5EED_1234));
    rst_n = 1'b0; in_valid = 0; in_a = 0; in_b_vec = 0; in_b_scalar = 0;
    in_use_scalar = 0; in_mode = 0; out_ready = 0;
    repeat (3) @(negedge clk);
    #1;
    check(out_valid === 1'b0, "R11", "out_valid in reset", out_valid, 0);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    check(out_valid === 1'b0, "R11", "out_valid after release", out_valid, 0);
    check(in_ready === 1'b1, "R11", "in_ready after release", in_ready, 1);

    // Directed corners at full rate
    lat_mode = 1;
    for (int m = 0; m < 4; m++) begin
      step(1, 16'h8000, 16'h8000, 16'h1111, 0, 2'(m), 1);    // R6 min*min
      step(1, 16'h7FFF, 16'h7FFF, 16'h0, 0, 2'(m), 1);
      step(1, 16'h8000, 16'h7FFF, 16'h0, 0, 2'(m), 1);
      step(1, 16'h4000, 16'h0001, 16'h0, 0, 2'(m), 1);       // positive tie
      step(1, 16'hC000, 16'h0001, 16'h0, 0, 2'(m), 1);       // negative tie
      step(1, 16'h4000, 16'h0003, 16'h0, 0, 2'(m), 1);       // tie, odd quotient
      step(1, 16'h0003, 16'h0001, 16'h0, 0, 2'(m), 1);       // small residue
      step(1, 16'h1234, 16'hDEAD, 16'h0002, 1, 2'(m), 1);    // R12 scalar chosen
      step(1, 16'h8000, 16'h0005, 16'h8000, 1, 2'(m), 1);    // R12 + R6 via scalar
    end
    for (int i = 0; i < 400; i++)
      step(1, pick(), pick(), pick(), 1'($urandom), 2'($urandom), 1);
    drain();
    lat_mode = 0;

    // Random valid and back-pressure
    for (int i = 0; i < 4000; i++)
      step(($urandom % 4) != 0, pick(), pick(), pick(), 1'($urandom),
           2'($urandom), ($urandom % 3) != 0);
    drain();
    check(q.size() == 0, "R8", "all results delivered", q.size(), 0);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL R8 watchdog: actual=%0d expected=%0d", 150000, 0);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule